// File: doc/BRIEF.md
# Signal-Fail Detector With Hysteresis

This block decides whether a received line has degraded far enough to be declared in signal fail, and later whether it has recovered. It is fed one strobe per received frame together with that frame's parity error count, computed elsewhere. Frames are grouped into monitoring blocks. A block is judged bad when the errors it collected reach a per-block limit. The number of bad blocks is then totalled over an observation interval made of a fixed number of blocks.

Two fully independent evaluators carry out this windowed test. The first, the assert evaluator, runs while the flag is low. It raises the flag when an interval holds more bad blocks than its limit. The second, the release evaluator, runs while the flag is high. It lowers the flag when an interval holds fewer bad blocks than its own limit. Each evaluator has its own frame count, error limit, bad-block limit and interval length. Declaring and releasing can therefore use different windows and thresholds, which gives asymmetric hysteresis. Setting either length to zero switches that evaluator off.

Top module: `sf_hysteresis_detector`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sf_fail` is low, and every evaluator starts from an empty block and an empty interval.
- R2: A monitoring block spans the number of strobed frames given by the evaluator's frame count. The block is bad when the sum of their `frame_err` values is greater than or equal to the 4-bit error limit. The running sum saturates at 31, so a large sum still counts as bad and never wraps.
- R3: The assert evaluator raises `sf_fail` when one interval of its block count holds strictly more bad blocks than its bad-block limit. The flag goes high at the second rising edge after the edge that samples the interval's last frame strobe.
- R4: If the assert-side bad-block total equals the assert bad-block limit, `sf_fail` stays low.
- R5: The release evaluator lowers `sf_fail` when one interval holds strictly fewer bad blocks than its bad-block limit. It has the same two-edge latency as R3.
- R6: If the release-side bad-block total equals the release bad-block limit, `sf_fail` stays high.
- R7: A frame strobe goes to the assert evaluator if `sf_fail` was low before the sampling edge, and to the release evaluator if it was high. Frames sampled while a flag change is still pending are dropped. After every flag change, the newly active evaluator starts from an empty block and an empty interval.
- R8: An evaluator whose frame count or block count is zero never changes `sf_fail`.
- R9: `frame_err` has no effect in cycles where `frame_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| frame_err | input | ERR_W (8) | Parity error count of the strobed frame |
| asrt_frames | input | NS_W (19) | Assert side: frames per monitoring block |
| asrt_err_lim | input | L_W (4) | Assert side: error limit for a bad block |
| asrt_bad_lim | input | M_W (8) | Assert side: bad-block limit per interval |
| asrt_blocks | input | B_W (16) | Assert side: blocks per interval |
| rlse_frames | input | NS_W (19) | Release side: frames per monitoring block |
| rlse_err_lim | input | L_W (4) | Release side: error limit for a bad block |
| rlse_bad_lim | input | M_W (8) | Release side: bad-block limit per interval |
| rlse_blocks | input | B_W (16) | Release side: blocks per interval |
| sf_fail | output | 1 | Registered signal-fail flag |

## Verification
The hazard occurs when the assert evaluator's decision falls in the same cycle as a new frame strobe. The flag flips in that cycle, so the frame could be counted by the wrong evaluator or counted twice. The bench provokes this by strobing frames on every clock across a one-frame, one-block assert window. It then checks the flag cycle by cycle against the edge at which the release interval should complete, given the R7 hand-over rule. A near-exhaustive sweep of small parameter sets also runs, with junk error values driven between strobes. It is compared against an arithmetic model of the two windows.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int NUM_SIDES   = 2;
  localparam int SIDE_ASRT_IX = 0;
  localparam int SIDE_RLSE_IX = 1;

  typedef enum logic {
    ST_CLEAR = 1'b0,
    ST_FAIL  = 1'b1
  } sf_state_e;
endpackage

// File: rtl/sfd_block_acc.sv
module sfd_block_acc #(
  parameter int ERR_W = 8,
  parameter int NS_W  = 19,
  parameter int L_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             stb,
  input  logic [ERR_W-1:0] err,
  input  logic [NS_W-1:0]  frames,
  input  logic [L_W-1:0]   err_lim,
  output logic             blk_done,
  output logic             blk_bad
);
  localparam int ACC_W = L_W + 1;
  localparam int SUM_W = ACC_W + ERR_W;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [NS_W-1:0]  frame_cnt;
  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum_raw;
  logic [ACC_W-1:0] sum_sat;
  logic             blk_end;

  always_comb begin
    sum_raw = SUM_W'(acc) + SUM_W'(err);
    sum_sat = (sum_raw > SUM_W'(ACC_MAX)) ? ACC_MAX : sum_raw[ACC_W-1:0];
    blk_end = (frame_cnt == (frames - NS_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      frame_cnt <= '0;
      acc       <= '0;
      blk_done  <= 1'b0;
      blk_bad   <= 1'b0;
    end else begin
      blk_done <= 1'b0;
      if (stb) begin
        if (blk_end) begin
          frame_cnt <= '0;
          acc       <= '0;
          blk_done  <= 1'b1;
          blk_bad   <= (sum_sat >= {1'b0, err_lim});
        end else begin
          frame_cnt <= frame_cnt + NS_W'(1);
          acc       <= sum_sat;
        end
      end
    end
  end

  a_r9_acc_idle: assert property (@(posedge clk) disable iff (rst)
    (en && !stb) |=> $stable(acc));

  a_r2_acc_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && stb && !blk_end) |=> (acc >= $past(acc)));
endmodule

// File: rtl/sfd_interval_cnt.sv
module sfd_interval_cnt #(
  parameter int B_W   = 16,
  parameter int BAD_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             blk_done,
  input  logic             blk_bad,
  input  logic [B_W-1:0]   blocks,
  output logic             iv_done,
  output logic [BAD_W-1:0] iv_bad
);
  localparam logic [BAD_W-1:0] BAD_MAX = '1;

  logic [B_W-1:0]   blk_cnt;
  logic [BAD_W-1:0] bad_cnt;
  logic [BAD_W-1:0] bad_next;
  logic             iv_end;

  always_comb begin
    bad_next = (bad_cnt == BAD_MAX) ? bad_cnt : bad_cnt + BAD_W'(blk_bad);
    iv_end   = (blk_cnt == (blocks - B_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      blk_cnt <= '0;
      bad_cnt <= '0;
      iv_done <= 1'b0;
      iv_bad  <= '0;
    end else begin
      iv_done <= 1'b0;
      if (blk_done) begin
        if (iv_end) begin
          blk_cnt <= '0;
          bad_cnt <= '0;
          iv_done <= 1'b1;
          iv_bad  <= bad_next;
        end else begin
          blk_cnt <= blk_cnt + B_W'(1);
          bad_cnt <= bad_next;
        end
      end
    end
  end

  a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !iv_done);

  a_r2_bad_monotone: assert property (@(posedge clk) disable iff (rst)
    (en && blk_done && !iv_end) |=> (bad_cnt >= $past(bad_cnt)));
endmodule

// File: rtl/sfd_side_eval.sv
module sfd_side_eval #(
  parameter int ERR_W = 8,
  parameter int NS_W  = 19,
  parameter int L_W   = 4,
  parameter int B_W   = 16,
  parameter int BAD_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             stb,
  input  logic [ERR_W-1:0] err,
  input  logic [NS_W-1:0]  frames,
  input  logic [L_W-1:0]   err_lim,
  input  logic [B_W-1:0]   blocks,
  output logic             iv_done,
  output logic [BAD_W-1:0] iv_bad
);
  logic en;
  logic blk_done;
  logic blk_bad;

  assign en = active && (frames != '0) && (blocks != '0);

  sfd_block_acc #(
    .ERR_W(ERR_W), .NS_W(NS_W), .L_W(L_W)
  ) u_blk (
    .clk(clk), .rst(rst), .en(en), .stb(stb), .err(err),
    .frames(frames), .err_lim(err_lim),
    .blk_done(blk_done), .blk_bad(blk_bad)
  );

  sfd_interval_cnt #(
    .B_W(B_W), .BAD_W(BAD_W)
  ) u_iv (
    .clk(clk), .rst(rst), .en(en), .blk_done(blk_done), .blk_bad(blk_bad),
    .blocks(blocks), .iv_done(iv_done), .iv_bad(iv_bad)
  );

  a_r8_disabled_no_block: assert property (@(posedge clk) disable iff (rst)
    !en |=> !blk_done);
endmodule

// File: rtl/sf_hysteresis_detector.sv
module sf_hysteresis_detector #(
  parameter int ERR_W = 8,
  parameter int NS_W  = 19,
  parameter int L_W   = 4,
  parameter int M_W   = 8,
  parameter int B_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic [ERR_W-1:0] frame_err,
  input  logic [NS_W-1:0]  asrt_frames,
  input  logic [L_W-1:0]   asrt_err_lim,
  input  logic [M_W-1:0]   asrt_bad_lim,
  input  logic [B_W-1:0]   asrt_blocks,
  input  logic [NS_W-1:0]  rlse_frames,
  input  logic [L_W-1:0]   rlse_err_lim,
  input  logic [M_W-1:0]   rlse_bad_lim,
  input  logic [B_W-1:0]   rlse_blocks,
  output logic             sf_fail
);
  import sfd_pkg::*;

  localparam int BAD_W = M_W + 1;

  sf_state_e state;

  logic [NUM_SIDES-1:0][NS_W-1:0]  frames_v;
  logic [NUM_SIDES-1:0][L_W-1:0]   err_lim_v;
  logic [NUM_SIDES-1:0][B_W-1:0]   blocks_v;
  logic [NUM_SIDES-1:0]            active_v;
  logic [NUM_SIDES-1:0]            iv_done_v;
  logic [NUM_SIDES-1:0][BAD_W-1:0] iv_bad_v;
  logic                            asrt_fire;
  logic                            rlse_fire;

  assign frames_v[SIDE_ASRT_IX]  = asrt_frames;
  assign err_lim_v[SIDE_ASRT_IX] = asrt_err_lim;
  assign blocks_v[SIDE_ASRT_IX]  = asrt_blocks;
  assign frames_v[SIDE_RLSE_IX]  = rlse_frames;
  assign err_lim_v[SIDE_RLSE_IX] = rlse_err_lim;
  assign blocks_v[SIDE_RLSE_IX]  = rlse_blocks;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    if (g == SIDE_ASRT_IX) begin : g_asrt
      assign active_v[g] = (state == ST_CLEAR);
    end else begin : g_rlse
      assign active_v[g] = (state == ST_FAIL);
    end

    sfd_side_eval #(
      .ERR_W(ERR_W), .NS_W(NS_W), .L_W(L_W), .B_W(B_W), .BAD_W(BAD_W)
    ) u_eval (
      .clk(clk), .rst(rst), .active(active_v[g]),
      .stb(frame_stb), .err(frame_err),
      .frames(frames_v[g]), .err_lim(err_lim_v[g]), .blocks(blocks_v[g]),
      .iv_done(iv_done_v[g]), .iv_bad(iv_bad_v[g])
    );
  end

  always_comb begin
    asrt_fire = iv_done_v[SIDE_ASRT_IX] &&
                (iv_bad_v[SIDE_ASRT_IX] > {1'b0, asrt_bad_lim});
    rlse_fire = iv_done_v[SIDE_RLSE_IX] &&
                (iv_bad_v[SIDE_RLSE_IX] < {1'b0, rlse_bad_lim});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CLEAR;
    end else if (state == ST_CLEAR && asrt_fire) begin
      state <= ST_FAIL;
    end else if (state == ST_FAIL && rlse_fire) begin
      state <= ST_CLEAR;
    end
  end

  assign sf_fail = (state == ST_FAIL);

  a_r3_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sf_fail) |-> $past(iv_done_v[SIDE_ASRT_IX] &&
                             (iv_bad_v[SIDE_ASRT_IX] > {1'b0, asrt_bad_lim})));

  a_r5_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(sf_fail) |-> $past(iv_done_v[SIDE_RLSE_IX] &&
                             (iv_bad_v[SIDE_RLSE_IX] < {1'b0, rlse_bad_lim})));

  a_r7_one_side_decides: assert property (@(posedge clk) disable iff (rst)
    !(iv_done_v[SIDE_ASRT_IX] && iv_done_v[SIDE_RLSE_IX]));

  a_r1_clear_after_reset: assert property (@(posedge clk)
    rst |=> !sf_fail);
endmodule

// File: tb/test_sf_hysteresis_detector.sv
`timescale 1ns/1ps
module test_sf_hysteresis_detector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic [7:0]  err = 8'h00;
  logic [18:0] a_ns = '0, r_ns = '0;
  logic [3:0]  a_l = '0, r_l = '0;
  logic [7:0]  a_m = '0, r_m = '0;
  logic [15:0] a_b = '0, r_b = '0;
  logic        sf;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  int m_sf;
  int sa_fc, sa_acc, sa_bc, sa_bad;
  int sr_fc, sr_acc, sr_bc, sr_bad;

  always #4 clk = ~clk;

  sf_hysteresis_detector i_sf_hysteresis_detector (
    .clk(clk), .rst(rst), .frame_stb(stb), .frame_err(err),
    .asrt_frames(a_ns), .asrt_err_lim(a_l), .asrt_bad_lim(a_m), .asrt_blocks(a_b),
    .rlse_frames(r_ns), .rlse_err_lim(r_l), .rlse_bad_lim(r_m), .rlse_blocks(r_b),
    .sf_fail(sf)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_sf = 0;
    sa_fc = 0; sa_acc = 0; sa_bc = 0; sa_bad = 0;
    sr_fc = 0; sr_acc = 0; sr_bc = 0; sr_bad = 0;
  endtask

  task automatic model_frame(input int e);
    if (m_sf == 0) begin
      if (a_ns != 0 && a_b != 0) begin
        sa_acc += e; sa_fc++;
        if (sa_fc == int'(a_ns)) begin
          if (sa_acc >= int'(a_l)) sa_bad++;
          sa_fc = 0; sa_acc = 0; sa_bc++;
          if (sa_bc == int'(a_b)) begin
            if (sa_bad > int'(a_m)) m_sf = 1;
            sa_bc = 0; sa_bad = 0;
          end
        end
      end
    end else begin
      if (r_ns != 0 && r_b != 0) begin
        sr_acc += e; sr_fc++;
        if (sr_fc == int'(r_ns)) begin
          if (sr_acc >= int'(r_l)) sr_bad++;
          sr_fc = 0; sr_acc = 0; sr_bc++;
          if (sr_bc == int'(r_b)) begin
            if (sr_bad < int'(r_m)) m_sf = 0;
            sr_bc = 0; sr_bad = 0;
          end
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic cfg(input int an, input int al, input int am, input int ab,
                     input int rn, input int rl, input int rm, input int rb);
    a_ns = 19'(an); a_l = 4'(al); a_m = 8'(am); a_b = 16'(ab);
    r_ns = 19'(rn); r_l = 4'(rl); r_m = 8'(rm); r_b = 16'(rb);
    do_reset();
  endtask

  // one strobed frame, then idle cycles carrying junk error values (R9)
  task automatic send(input int e);
    @(negedge clk);
    stb = 1'b1; err = 8'(e);
    @(negedge clk);
    stb = 1'b0; err = 8'hA5;
    repeat (3) @(negedge clk);
    model_frame(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int exp_r7 [7];

    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(int'(sf), 0, "R1 flag low during reset");
    rst = 1'b0;
    @(negedge clk);
    chk(int'(sf), 0, "R1 flag low after reset");

    // R3: latency, one frame one block
    cfg(1, 1, 0, 1, 0, 0, 0, 0);
    @(negedge clk); stb = 1'b1; err = 8'd1;
    @(negedge clk); stb = 1'b0; err = 8'd0;
    chk(int'(sf), 0, "R3 one edge after last frame");
    @(negedge clk);
    chk(int'(sf), 0, "R3 two edges after last frame");
    @(negedge clk);
    chk(int'(sf), 1, "R3 three edges after last frame");

    // R2: error equal to limit counts as bad; saturation instead of wrap
    cfg(1, 2, 0, 1, 0, 0, 0, 0);
    send(2);
    chk(int'(sf), 1, "R2 errors equal to limit make block bad");
    cfg(1, 3, 0, 1, 0, 0, 0, 0);
    send(2);
    chk(int'(sf), 0, "R2 errors below limit keep block good");
    cfg(2, 15, 0, 1, 0, 0, 0, 0);
    send(17); send(15);
    chk(int'(sf), 1, "R2 saturated sum still bad");

    // R4: equal bad count does not set
    cfg(1, 2, 1, 2, 0, 0, 0, 0);
    send(2); send(1);
    chk(int'(sf), 0, "R4 bad count equal to limit");
    send(2); send(2);
    chk(int'(sf), 1, "R3 bad count above limit");

    // R6, R5, R7 sequence
    cfg(1, 1, 0, 2, 1, 1, 1, 2);
    send(1); send(0);
    chk(int'(sf), 1, "R3 set before release test");
    send(1); send(0);
    chk(int'(sf), 1, "R6 release count equal to limit");
    send(0); send(0);
    chk(int'(sf), 0, "R5 release count below limit");
    send(1);
    chk(int'(sf), 0, "R7 assert side restarted empty");
    send(0);
    chk(int'(sf), 1, "R7 assert side full interval");

    // R8: zero frame count or zero block count disables
    cfg(0, 1, 0, 1, 0, 0, 0, 0);
    send(5); send(5); send(5);
    chk(int'(sf), 0, "R8 zero frames per block");
    cfg(1, 1, 0, 0, 0, 0, 0, 0);
    send(5); send(5); send(5);
    chk(int'(sf), 0, "R8 zero blocks per interval");
    cfg(1, 1, 0, 1, 0, 1, 1, 1);
    send(5);
    chk(int'(sf), 1, "R8 control set");
    send(0); send(0);
    chk(int'(sf), 1, "R8 release side disabled");

    // R7: back-to-back strobes across the flag change
    cfg(1, 1, 0, 1, 1, 1, 1, 2);
    exp_r7 = '{0, 0, 1, 1, 1, 1, 0};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) chk(int'(sf), exp_r7[i-1], $sformatf("R7 stream edge %0d", i - 1));
      if (i < 3) begin stb = 1'b1; err = 8'd1; end
      else if (i < 5) begin stb = 1'b1; err = 8'd0; end
      else begin stb = 1'b0; err = 8'hFF; end
    end
    stb = 1'b0;

    // sweep over small configurations against the arithmetic model
    lfsr = 16'hACE1;
    for (int sn = 1; sn <= 2; sn++)
      for (int sl = 1; sl <= 3; sl++)
        for (int sb = 1; sb <= 3; sb++)
          for (int sm = 0; sm <= 2; sm++) begin
            cfg(sn, sl, sm, sb, 1 + ((sl + sb) % 2), 1 + (sm % 2),
                1 + (sl % 3), 1 + ((sn + sm) % 3));
            for (int f = 0; f < 30; f++) begin
              int e;
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              e = (lfsr[7:4] == 4'd0) ? 250 : int'(lfsr[1:0]);
              send(e);
              chk(int'(sf), m_sf, "R2 R3 R4 R5 R6 R7 R9 sweep");
            end
          end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule